// File: doc/BRIEF.md
# Crate Command Frame Parser

This block sits behind the line decoder of a crate controller's command port. Each input frame has already been recovered and handed over as a payload word, plus one header bit that tells whether the payload is 16 or 24 bits wide. The block walks through the frames of one command and pulls out the fields. The first frame carries the crate address. The second carries the slot, subaddress and function (NAF). Write functions add one frame of write data. A block-transfer setup adds two frames: the target NAF, and then the word-count and no-Q limits.

The parser checks the separator bits and the field ranges of every NAF frame. It also checks that each frame arrives with the width the current step expects. A failed check raises a sticky protocol error flag for the response path, and the parser goes back to waiting for the crate frame. A finished plain or write command gives a one-cycle `cmd_valid` pulse. A finished block-transfer setup gives a one-cycle `bt_setup_valid` pulse. The decoded fields are held until they are replaced.

Top module: `crate_cmd_parser`

## Requirements
- R1: After reset the parser waits for a crate frame, and `cmd_valid`, `bt_setup_valid`, `perr`, `nafok` and `nafok_bt` are all 0.
- R2: While waiting for a crate frame, a 16-bit frame (`frm_wide`=0) loads `crate` from payload bits 15:0 and clears `perr`, `nafok` and `nafok_bt`. A 24-bit frame in that step is dropped: it changes no output and raises no flag.
- R3: In the NAF frame, N is in bits 15:11, A in bits 9:6 and F in bits 4:0, and bits 10 and 5 are separators. The frame is accepted, and `nafok` is set to 1, only when both separators are 1 and N ≤ 24. Otherwise `nafok` is 0.
- R4: An accepted NAF frame that is neither a write nor a block-transfer setup updates `n`, `a` and `f` and pulses `cmd_valid` high for exactly one cycle, in the cycle after the frame.
- R5: A function with F[4]=1 and F[3]=0 (F16..F23) is a write, unless the NAF is the setup code of R6. For a write, the parser waits for a 24-bit frame, loads `wdata` from its payload, and then pulses `cmd_valid`. The NAF frame itself gives no pulse.
- R6: The NAF N=24, A=15, F=16 is a block-transfer setup. The next frame is 16 bits wide and uses the same field layout as R3. It is accepted, with `nafok_bt` set to 1 and `bt_n`/`bt_a`/`bt_f` loaded, only when both separators are 0, N ≤ 23 and F ≤ 7.
- R7: After an accepted setup NAF, a 24-bit frame loads `bt_wc` from bits 23:8 (the transfer count minus one) and `bt_maxnoq` from bits 7:0. It pulses `bt_setup_valid` for one cycle and leaves `cmd_valid` low.
- R8: Any of the following sets `perr` to 1 and returns the parser to waiting for a crate frame: a rejected NAF frame, a rejected setup NAF frame, or a frame after the first whose width differs from the one the current step expects.
- R9: `perr` stays 1 until the next accepted crate frame.
- R10: `cmd_valid` and `bt_setup_valid` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | One received frame is present this cycle |
| frm_wide | input | 1 | Payload width header bit: 0 = 16 bits, 1 = 24 bits |
| frm_data | input | 24 | Frame payload; a 16-bit payload sits in bits 15:0 |
| cmd_valid | output | 1 | One-cycle strobe: a plain or write command is complete |
| crate | output | 16 | Crate address of the current command |
| n | output | 5 | Slot number |
| a | output | 4 | Subaddress |
| f | output | 5 | Function code |
| wdata | output | 24 | Write data |
| bt_setup_valid | output | 1 | One-cycle strobe: a block-transfer setup is complete |
| bt_n | output | 5 | Block-transfer target slot |
| bt_a | output | 4 | Block-transfer target subaddress |
| bt_f | output | 5 | Block-transfer target function |
| bt_wc | output | 16 | Word count field (transfers minus one) |
| bt_maxnoq | output | 8 | Maximum no-Q count field |
| nafok | output | 1 | The last NAF frame passed its checks |
| nafok_bt | output | 1 | The last setup NAF frame passed its checks |
| perr | output | 1 | Sticky protocol error |

## Verification
The bench targets the range limits on both sides: N of 24 against 25 for a command NAF, and N of 23 against 24 and F of 7 against 8 for a setup NAF. A design with an off-by-one limit would raise or miss `perr` on exactly those frames. It flips each separator bit on its own, so a design that checks only one separator, or checks the wrong polarity for a setup NAF, accepts a bad frame. It sends frames of the wrong width at every step and then a crate frame. A parser that does not abort would treat that crate frame as NAF or data, and one that does not drop a wide first frame would load a wrong crate address. It also sends the setup code, which falls inside the write function range, so a design that tests for a write first would wait for write data instead of the setup frames.

// File: rtl/crate_cmd_parser.sv
module crate_cmd_parser #(
  parameter int WIDE_W   = 24,
  parameter int NARROW_W = 16,
  parameter int NMAX     = 24,
  parameter int BT_NMAX  = 23,
  parameter int BT_FMAX  = 7,
  parameter int SETUP_N  = 24,
  parameter int SETUP_A  = 15,
  parameter int SETUP_F  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frm_valid,
  input  logic                     frm_wide,
  input  logic [WIDE_W-1:0]        frm_data,
  output logic                     cmd_valid,
  output logic [NARROW_W-1:0]      crate,
  output logic [4:0]               n,
  output logic [3:0]               a,
  output logic [4:0]               f,
  output logic [WIDE_W-1:0]        wdata,
  output logic                     bt_setup_valid,
  output logic [4:0]               bt_n,
  output logic [3:0]               bt_a,
  output logic [4:0]               bt_f,
  output logic [NARROW_W-1:0]      bt_wc,
  output logic [WIDE_W-NARROW_W-1:0] bt_maxnoq,
  output logic                     nafok,
  output logic                     nafok_bt,
  output logic                     perr
);

  localparam int QW = WIDE_W - NARROW_W;
  localparam logic [4:0] N_LIM    = 5'(NMAX);
  localparam logic [4:0] BTN_LIM  = 5'(BT_NMAX);
  localparam logic [4:0] BTF_LIM  = 5'(BT_FMAX);
  localparam logic [4:0] SU_N     = 5'(SETUP_N);
  localparam logic [3:0] SU_A     = 4'(SETUP_A);
  localparam logic [4:0] SU_F     = 5'(SETUP_F);

  typedef enum logic [2:0] {S_CRATE, S_NAF, S_WDATA, S_BTNAF, S_BTCNT} st_t;
  st_t st;

  logic [4:0] fn, ff;
  logic [3:0] fa;
  logic       sep_hi, sep_lo;
  assign fn     = frm_data[15:11];
  assign sep_hi = frm_data[10];
  assign fa     = frm_data[9:6];
  assign sep_lo = frm_data[5];
  assign ff     = frm_data[4:0];

  logic naf_good, bt_good, is_setup, is_write, want_wide, width_bad;
  assign naf_good  = sep_hi & sep_lo & (fn <= N_LIM);
  assign bt_good   = ~sep_hi & ~sep_lo & (fn <= BTN_LIM) & (ff <= BTF_LIM);
  assign is_setup  = (fn == SU_N) && (fa == SU_A) && (ff == SU_F);
  assign is_write  = ff[4] & ~ff[3];
  assign want_wide = (st == S_WDATA) || (st == S_BTCNT);
  assign width_bad = frm_wide != want_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_CRATE;
      cmd_valid      <= 1'b0;
      bt_setup_valid <= 1'b0;
      crate          <= '0;
      n              <= '0;
      a              <= '0;
      f              <= '0;
      wdata          <= '0;
      bt_n           <= '0;
      bt_a           <= '0;
      bt_f           <= '0;
      bt_wc          <= '0;
      bt_maxnoq      <= '0;
      nafok          <= 1'b0;
      nafok_bt       <= 1'b0;
      perr           <= 1'b0;
    end else begin
      cmd_valid      <= 1'b0;
      bt_setup_valid <= 1'b0;
      if (frm_valid) begin
        if (st == S_CRATE) begin
          if (!frm_wide) begin
            crate    <= frm_data[NARROW_W-1:0];
            perr     <= 1'b0;
            nafok    <= 1'b0;
            nafok_bt <= 1'b0;
            st       <= S_NAF;
          end
        end else if (width_bad) begin
          perr <= 1'b1;
          st   <= S_CRATE;
        end else begin
          case (st)
            S_NAF: begin
              nafok <= naf_good;
              if (!naf_good) begin
                perr <= 1'b1;
                st   <= S_CRATE;
              end else begin
                n <= fn;
                a <= fa;
                f <= ff;
                if (is_setup)      st <= S_BTNAF;
                else if (is_write) st <= S_WDATA;
                else begin
                  cmd_valid <= 1'b1;
                  st        <= S_CRATE;
                end
              end
            end
            S_WDATA: begin
              wdata     <= frm_data;
              cmd_valid <= 1'b1;
              st        <= S_CRATE;
            end
            S_BTNAF: begin
              nafok_bt <= bt_good;
              if (!bt_good) begin
                perr <= 1'b1;
                st   <= S_CRATE;
              end else begin
                bt_n <= fn;
                bt_a <= fa;
                bt_f <= ff;
                st   <= S_BTCNT;
              end
            end
            S_BTCNT: begin
              bt_wc          <= frm_data[WIDE_W-1 -: NARROW_W];
              bt_maxnoq      <= frm_data[QW-1:0];
              bt_setup_valid <= 1'b1;
              st             <= S_CRATE;
            end
            default: st <= S_CRATE;
          endcase
        end
      end
    end
  end

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && bt_setup_valid));

  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R4
  cmd_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(frm_valid));

  // R3
  cmd_needs_nafok_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> nafok);

  // R7
  setup_needs_btok_chk: assert property (@(posedge clk) disable iff (rst)
    bt_setup_valid |-> (nafok_bt && nafok && $past(frm_valid && frm_wide)));

  // R8
  err_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(perr) |-> (st == S_CRATE && $past(frm_valid)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (perr && !(frm_valid && !frm_wide && st == S_CRATE)) |=> perr);

endmodule

// File: tb/crate_cmd_parser_tb.sv
`timescale 1ns/1ps
module crate_cmd_parser_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        frm_valid = 0;
  logic        frm_wide = 0;
  logic [23:0] frm_data = '0;
  logic        cmd_valid, bt_setup_valid, nafok, nafok_bt, perr;
  logic [15:0] crate, bt_wc;
  logic [4:0]  n, f, bt_n, bt_f;
  logic [3:0]  a, bt_a;
  logic [23:0] wdata;
  logic [7:0]  bt_maxnoq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  crate_cmd_parser dut_i (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_wide(frm_wide), .frm_data(frm_data),
    .cmd_valid(cmd_valid), .crate(crate), .n(n), .a(a), .f(f), .wdata(wdata),
    .bt_setup_valid(bt_setup_valid), .bt_n(bt_n), .bt_a(bt_a), .bt_f(bt_f),
    .bt_wc(bt_wc), .bt_maxnoq(bt_maxnoq), .nafok(nafok), .nafok_bt(nafok_bt), .perr(perr)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input bit wide, input logic [23:0] d);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_wide  = wide;
    frm_data  = d;
    @(negedge clk);
    frm_valid = 1'b0;
    frm_data  = $urandom;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  function automatic logic [23:0] naf_word(input logic [4:0] nn, input logic [3:0] aa,
                                           input logic [4:0] ff, input bit s1, input bit s2);
    return {8'h00, nn, s1, aa, s2, ff};
  endfunction

  function automatic bit exp_nafok(input logic [23:0] w);
    return w[10] && w[5] && (w[15:11] <= 5'd24);
  endfunction

  function automatic bit exp_btok(input logic [23:0] w);
    return !w[10] && !w[5] && (w[15:11] <= 5'd23) && (w[4:0] <= 5'd7);
  endfunction

  function automatic bit exp_setup(input logic [23:0] w);
    return w[15:11] == 5'd24 && w[9:6] == 4'd15 && w[4:0] == 5'd16;
  endfunction

  function automatic bit exp_write(input logic [23:0] w);
    return w[4] && !w[3];
  endfunction

  task automatic run_cmd(input logic [15:0] cr, input logic [23:0] w,
                         input logic [23:0] w3, input logic [23:0] w4);
    bit ok, bok;
    send(0, {8'h00, cr});
    chk("R2", "crate", crate, cr);
    chk("R9", "perr cleared by crate frame", perr, 0);
    chk("R2", "nafok cleared", nafok, 0);
    send(0, w);
    ok = exp_nafok(w);
    chk("R3", "nafok", nafok, ok);
    if (!ok) begin
      chk("R8", "perr after bad naf", perr, 1);
      chk("R3", "no strobe after bad naf", cmd_valid, 0);
      return;
    end
    if (exp_setup(w)) begin
      chk("R6", "no cmd strobe on setup naf", cmd_valid, 0);
      send(0, w3);
      bok = exp_btok(w3);
      chk("R6", "nafok_bt", nafok_bt, bok);
      if (!bok) begin
        chk("R8", "perr after bad bt naf", perr, 1);
        return;
      end
      chk("R6", "bt naf fields", {bt_n, bt_a, bt_f}, {w3[15:11], w3[9:6], w3[4:0]});
      send(1, w4);
      chk("R7", "bt_setup_valid", bt_setup_valid, 1);
      chk("R7", "no cmd strobe", cmd_valid, 0);
      chk("R7", "bt_wc", bt_wc, w4[23:8]);
      chk("R7", "bt_maxnoq", bt_maxnoq, w4[7:0]);
      chk("R8", "perr stays clear", perr, 0);
      idle(1);
      chk("R10", "bt strobe one cycle", bt_setup_valid, 0);
    end else if (exp_write(w)) begin
      chk("R5", "no strobe before write data", cmd_valid, 0);
      send(1, w3);
      chk("R5", "cmd_valid after write data", cmd_valid, 1);
      chk("R5", "wdata", wdata, w3);
      chk("R5", "naf of write", {n, a, f}, {w[15:11], w[9:6], w[4:0]});
      idle(1);
      chk("R10", "write strobe one cycle", cmd_valid, 0);
    end else begin
      chk("R4", "cmd_valid", cmd_valid, 1);
      chk("R4", "naf fields", {n, a, f}, {w[15:11], w[9:6], w[4:0]});
      chk("R10", "bt strobe low", bt_setup_valid, 0);
      idle(1);
      chk("R4", "strobe one cycle", cmd_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] w, w3, w4;
    logic [4:0]  rn, rf;
    logic [3:0]  ra;
    bit s1, s2;
    int kind;
    void'($urandom(32'd2718));
    idle(3);
    @(negedge clk) rst = 0;
    idle(1);
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "bt_setup_valid", bt_setup_valid, 0);
    chk("R1", "perr", perr, 0);
    chk("R1", "nafok", nafok, 0);
    chk("R1", "nafok_bt", nafok_bt, 0);

    // wide frame while waiting for crate is dropped
    send(1, 24'hABCDEF);
    chk("R2", "wide first frame ignored crate", crate, 16'h0000);
    chk("R2", "wide first frame no perr", perr, 0);
    run_cmd(16'h1234, naf_word(5'd3, 4'd2, 5'd1, 1, 1), '0, '0);

    // N limits
    run_cmd(16'h0001, naf_word(5'd24, 4'd0, 5'd0, 1, 1), '0, '0);
    run_cmd(16'h0002, naf_word(5'd25, 4'd0, 5'd0, 1, 1), '0, '0);
    run_cmd(16'h0003, naf_word(5'd5, 4'd0, 5'd0, 0, 1), '0, '0);
    run_cmd(16'h0004, naf_word(5'd5, 4'd0, 5'd0, 1, 0), '0, '0);
    chk("R9", "perr held idle", perr, 1);
    idle(6);
    chk("R9", "perr still held", perr, 1);

    // width mismatch on NAF frame
    send(0, 24'h00BEEF);
    send(1, {8'hFF, naf_word(5'd1, 4'd1, 5'd1, 1, 1)});
    chk("R8", "perr on wide naf", perr, 1);
    chk("R8", "no strobe on wide naf", cmd_valid, 0);
    send(0, 24'h005A5A);
    chk("R8", "parser back at crate step", crate, 16'h5A5A);
    chk("R9", "perr cleared", perr, 0);

    // width mismatch on write data
    send(0, naf_word(5'd7, 4'd3, 5'd17, 1, 1));
    chk("R5", "write naf no strobe", cmd_valid, 0);
    send(0, 24'h000123);
    chk("R8", "perr on narrow write data", perr, 1);
    chk("R8", "no strobe on narrow write data", cmd_valid, 0);

    // write boundaries F16 and F23, non-write F24
    run_cmd(16'h0010, naf_word(5'd2, 4'd0, 5'd16, 1, 1), 24'h800001, '0);
    run_cmd(16'h0011, naf_word(5'd2, 4'd0, 5'd23, 1, 1), 24'h7FFFFE, '0);
    run_cmd(16'h0012, naf_word(5'd2, 4'd0, 5'd24, 1, 1), '0, '0);

    // setup with limits
    w = naf_word(5'd24, 4'd15, 5'd16, 1, 1);
    run_cmd(16'h0020, w, naf_word(5'd23, 4'd9, 5'd7, 0, 0), 24'hFFFFFF);
    run_cmd(16'h0021, w, naf_word(5'd0, 4'd0, 5'd0, 0, 0), 24'h000000);
    run_cmd(16'h0022, w, naf_word(5'd24, 4'd0, 5'd0, 0, 0), '0);
    run_cmd(16'h0023, w, naf_word(5'd3, 4'd0, 5'd8, 0, 0), '0);
    run_cmd(16'h0024, w, naf_word(5'd3, 4'd0, 5'd2, 1, 0), '0);
    run_cmd(16'h0025, w, naf_word(5'd3, 4'd0, 5'd2, 0, 1), '0);

    // setup count frame of wrong width
    send(0, 24'h000026);
    send(0, w);
    send(0, naf_word(5'd4, 4'd1, 5'd2, 0, 0));
    chk("R6", "bt naf accepted", nafok_bt, 1);
    send(0, 24'h001234);
    chk("R8", "perr on narrow count frame", perr, 1);
    chk("R7", "no setup strobe", bt_setup_valid, 0);

    for (int it = 0; it < 400; it++) begin
      kind = $urandom_range(0, 3);
      rn = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(25, 31)) : 5'($urandom_range(0, 24));
      ra = 4'($urandom);
      rf = 5'($urandom);
      s1 = ($urandom_range(0, 9) != 0);
      s2 = ($urandom_range(0, 9) != 0);
      if (kind == 1) rf = 5'($urandom_range(16, 23));
      if (kind == 2) begin rn = 5'd24; ra = 4'd15; rf = 5'd16; s1 = 1; s2 = 1; end
      w  = naf_word(rn, ra, rf, s1, s2);
      if (kind == 2)
        w3 = naf_word(5'($urandom_range(0, 25)), 4'($urandom), 5'($urandom_range(0, 9)),
                      ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
      else
        w3 = 24'($urandom);
      w4 = 24'($urandom);
      run_cmd(16'($urandom), w, w3, w4);
      idle($urandom_range(0, 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule